// File: doc/BRIEF.md
# Addition-chain inversion sequencer

This block steers an external modular arithmetic unit through a field inversion for the prime 2^255-19. It works by Fermat exponentiation and raises the input x to p-2. The block does no arithmetic of its own. After a start pulse it presents micro-operations one at a time on a valid/completion handshake. Each micro-operation is either a move or a multiply.

A multiply whose two source slots are equal is a squaring. Long squaring runs come from a compact step table combined with an iteration counter, so they are not stored as a flat table. A run toggles between two scratch slots and between the two operand banks. Stored intermediates are copied across banks before the multiply that needs them. After the last micro-operation completes, the result sits in scratch slot 0 of the high bank and a done pulse is raised. The input x is expected in slot 2 of the low bank.

Top module: `inv_chain_seq`

## Requirements
- R1: After reset, `busy_o`, `uop_valid_o` and `seq_done_o` are 0, and they stay 0 while no start is given, even if `uop_done_i` toggles.
- R2: A start while idle is taken at the next clock edge. From the following cycle, `busy_o` and `uop_valid_o` are 1 and the first micro-operation is a move (opcode 0) from low bank (bank code 0) slot 2 to high bank (code 1) slot 2, with mod select 0.
- R3: While `uop_valid_o` is 1 and `uop_done_i` is 0, every micro-operation field holds its value.
- R4: The sequencer advances exactly once per completion. The next micro-operation is presented in the cycle after the completion edge, and the sequence has exactly 291 micro-operations.
- R5: Every micro-operation writes the bank opposite to the one it reads. Both operands of a multiply come from a single bank.
- R6: Every multiply (opcode 1) carries mod select 1, the doubled modulus. Every move carries mod select 0 and has equal source slots.
- R7: A squaring that directly follows a squaring reads the bank and slot the previous one wrote. Runs alternate between scratch slots 0 and 1.
- R8: The sequence issues exactly 254 squarings, 11 multiplies with distinct operands and 26 moves.
- R9: Slot codes are fixed: scratch 0/1 = 0/1, x = 2, x^2 = 3, x^9 = 4, x^11 = 5, and the 2^k-1 powers for k = 5, 10, 20, 40, 50, 100 are codes 6 to 11. Every operand read has been written earlier. If each move copies an exponent and each multiply adds two, high-bank slot 0 finally holds 2^255-21.
- R10: `seq_done_o` is a single-cycle pulse in the cycle after the last completion edge. In that cycle `uop_valid_o` and `busy_o` are 0.
- R11: A start pulse while busy has no effect on the sequence.
- R12: A start given immediately after the done pulse replays the identical sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| uop_done_i | input | 1 | Completion of the presented micro-operation |
| busy_o | output | 1 | Sequence in progress |
| uop_valid_o | output | 1 | Micro-operation fields valid |
| uop_op_o | output | 1 | Opcode: 0 move, 1 multiply |
| uop_src_bank_o | output | 1 | Source bank: 0 low, 1 high |
| uop_src_a_o | output | 4 | First source slot |
| uop_src_b_o | output | 4 | Second source slot |
| uop_dst_bank_o | output | 1 | Destination bank |
| uop_dst_o | output | 4 | Destination slot |
| uop_mod_o | output | 1 | Modulus select: 1 doubled modulus |
| seq_done_o | output | 1 | One-cycle done pulse |

## Verification
A start sampled at edge k shows up as valid fields at the sample point after edge k. A completion sampled at edge m is followed by the next operation, or by the done pulse, at the sample point after edge m. The done pulse is gone one sample later. The bench drives all inputs at the falling edge and reads the outputs there. It checks a new operation only one half-cycle after the edge that produced it, and it checks the done pulse on exactly two consecutive falling edges. Stall lengths of zero to three cycles exercise holding of the fields. The symbolic exponent model is applied at each completion, which makes the final result check independent of the latency.

// File: rtl/inv_seq_pkg.sv
package inv_seq_pkg;

  localparam int SLOT_W    = 4;
  localparam int MAX_RUN   = 100;
  localparam int ITER_W    = $clog2(MAX_RUN + 1);
  localparam int NUM_STEPS = 49;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  typedef enum logic {OP_MOVE = 1'b0, OP_MUL = 1'b1} op_e;
  typedef enum logic {BK_LO = 1'b0, BK_HI = 1'b1} bank_e;
  typedef enum logic {MD_P = 1'b0, MD_2P = 1'b1} mod_e;
  typedef logic [SLOT_W-1:0] slot_t;

  localparam slot_t SL_R1   = slot_t'(0);
  localparam slot_t SL_R2   = slot_t'(1);
  localparam slot_t SL_X1   = slot_t'(2);
  localparam slot_t SL_X2   = slot_t'(3);
  localparam slot_t SL_X9   = slot_t'(4);
  localparam slot_t SL_X11  = slot_t'(5);
  localparam slot_t SL_E5   = slot_t'(6);
  localparam slot_t SL_E10  = slot_t'(7);
  localparam slot_t SL_E20  = slot_t'(8);
  localparam slot_t SL_E40  = slot_t'(9);
  localparam slot_t SL_E50  = slot_t'(10);
  localparam slot_t SL_E100 = slot_t'(11);

  typedef struct packed {
    op_e   op;
    bank_e src_bk;
    slot_t src_a;
    slot_t src_b;
    bank_e dst_bk;
    slot_t dst;
    mod_e  md;
  } uop_t;

  typedef struct packed {
    logic              is_run;
    logic [ITER_W-1:0] run_len;
    uop_t              u;
  } step_t;

  function automatic bank_e other_bank(input bank_e b);
    return (b == BK_LO) ? BK_HI : BK_LO;
  endfunction

  function automatic slot_t other_scratch(input slot_t s);
    return (s == SL_R1) ? SL_R2 : SL_R1;
  endfunction

  function automatic step_t st_move(input bank_e b, input slot_t s, input slot_t d);
    step_t r;
    r.is_run   = 1'b0;
    r.run_len  = '0;
    r.u.op     = OP_MOVE;
    r.u.src_bk = b;
    r.u.src_a  = s;
    r.u.src_b  = s;
    r.u.dst_bk = other_bank(b);
    r.u.dst    = d;
    r.u.md     = MD_P;
    return r;
  endfunction

  function automatic step_t st_mul(input bank_e b, input slot_t a, input slot_t c,
                                   input slot_t d);
    step_t r;
    r.is_run   = 1'b0;
    r.run_len  = '0;
    r.u.op     = OP_MUL;
    r.u.src_bk = b;
    r.u.src_a  = a;
    r.u.src_b  = c;
    r.u.dst_bk = other_bank(b);
    r.u.dst    = d;
    r.u.md     = MD_2P;
    return r;
  endfunction

  // A run step keeps only its start bank and start scratch slot.
  function automatic step_t st_run(input bank_e b, input slot_t s, input int n);
    step_t r;
    r          = st_mul(b, s, s, other_scratch(s));
    r.is_run   = 1'b1;
    r.run_len  = ITER_W'(n);
    return r;
  endfunction

  // Iteration of a squaring run: even goes start->other bank, odd comes back.
  function automatic uop_t sqr_iter(input bank_e b0, input slot_t s0, input logic odd);
    uop_t u;
    u.op = OP_MUL;
    u.md = MD_2P;
    if (!odd) begin
      u.src_bk = b0;
      u.src_a  = s0;
      u.dst_bk = other_bank(b0);
      u.dst    = other_scratch(s0);
    end else begin
      u.src_bk = other_bank(b0);
      u.src_a  = other_scratch(s0);
      u.dst_bk = b0;
      u.dst    = s0;
    end
    u.src_b = u.src_a;
    return u;
  endfunction

  function automatic step_t chain_step(input logic [STEP_W-1:0] i);
    case (i)
      6'd0, 6'd1:   return st_move(BK_LO, SL_X1, SL_X1);
      6'd2:         return st_mul(BK_LO, SL_X1, SL_X1, SL_X2);
      6'd3:         return st_mul(BK_HI, SL_X2, SL_X2, SL_R1);
      6'd4:         return st_mul(BK_LO, SL_R1, SL_R1, SL_R2);
      6'd5:         return st_mul(BK_HI, SL_R2, SL_X1, SL_X9);
      6'd6, 6'd7:   return st_move(BK_HI, SL_X2, SL_X2);
      6'd8:         return st_mul(BK_LO, SL_X9, SL_X2, SL_X11);
      6'd9:         return st_mul(BK_HI, SL_X11, SL_X11, SL_R1);
      6'd10:        return st_mul(BK_LO, SL_R1, SL_X9, SL_E5);
      6'd11, 6'd12: return st_move(BK_HI, SL_E5, SL_R1);
      6'd13:        return st_run(BK_LO, SL_R1, 5);
      6'd14:        return st_mul(BK_HI, SL_R2, SL_E5, SL_E10);
      6'd15, 6'd16: return st_move(BK_LO, SL_E10, SL_R1);
      6'd17, 6'd18: return st_move(BK_LO, SL_E10, SL_E10);
      6'd19:        return st_run(BK_HI, SL_R1, 10);
      6'd20:        return st_mul(BK_HI, SL_R1, SL_E10, SL_E20);
      6'd21, 6'd22: return st_move(BK_LO, SL_E20, SL_R1);
      6'd23, 6'd24: return st_move(BK_LO, SL_E20, SL_E20);
      6'd25:        return st_run(BK_HI, SL_R1, 20);
      6'd26:        return st_mul(BK_HI, SL_R1, SL_E20, SL_E40);
      6'd27, 6'd28: return st_move(BK_LO, SL_E40, SL_R1);
      6'd29:        return st_run(BK_HI, SL_R1, 10);
      6'd30:        return st_mul(BK_HI, SL_R1, SL_E10, SL_E50);
      6'd31, 6'd32: return st_move(BK_LO, SL_E50, SL_R1);
      6'd33, 6'd34: return st_move(BK_LO, SL_E50, SL_E50);
      6'd35:        return st_run(BK_HI, SL_R1, 50);
      6'd36:        return st_mul(BK_HI, SL_R1, SL_E50, SL_E100);
      6'd37, 6'd38: return st_move(BK_LO, SL_E100, SL_R1);
      6'd39, 6'd40: return st_move(BK_LO, SL_E100, SL_E100);
      6'd41:        return st_run(BK_HI, SL_R1, 100);
      6'd42:        return st_mul(BK_HI, SL_R1, SL_E100, SL_R2);
      6'd43:        return st_run(BK_LO, SL_R2, 50);
      6'd44:        return st_mul(BK_LO, SL_R2, SL_E50, SL_R1);
      6'd45:        return st_run(BK_HI, SL_R1, 5);
      6'd46, 6'd47: return st_move(BK_HI, SL_X11, SL_X11);
      6'd48:        return st_mul(BK_LO, SL_R2, SL_X11, SL_R1);
      default:      return st_move(BK_LO, SL_R1, SL_R1);
    endcase
  endfunction

endpackage

// File: rtl/inv_step_rom.sv
module inv_step_rom
  import inv_seq_pkg::*;
(
  input  logic [STEP_W-1:0] step_idx_i,
  output step_t             step_o
);
  always_comb step_o = chain_step(step_idx_i);
endmodule

// File: rtl/inv_uop_expand.sv
module inv_uop_expand
  import inv_seq_pkg::*;
(
  input  step_t step_i,
  input  logic  iter_odd_i,
  output uop_t  uop_o
);
  always_comb begin
    if (step_i.is_run) uop_o = sqr_iter(step_i.u.src_bk, step_i.u.src_a, iter_odd_i);
    else               uop_o = step_i.u;
  end
endmodule

// File: rtl/inv_seq_ctrl.sv
module inv_seq_ctrl
  import inv_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              uop_done_i,
  input  logic              run_i,
  input  logic [ITER_W-1:0] run_len_i,
  output logic              busy_o,
  output logic [STEP_W-1:0] step_idx_o,
  output logic [ITER_W-1:0] loop_cnt_o,
  output logic              accept_o,
  output logic              last_o,
  output logic              done_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  logic busy_q, done_q;
  logic [STEP_W-1:0] step_q;
  logic [ITER_W-1:0] cnt_q;
  logic run_end;

  assign run_end  = !run_i || (cnt_q == run_len_i - ITER_W'(1));
  assign accept_o = busy_q && uop_done_i;
  assign last_o   = (step_q == LAST_STEP) && run_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= accept_o && last_o;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          step_q <= '0;
          cnt_q  <= '0;
        end
      end else if (accept_o) begin
        if (last_o) begin
          busy_q <= 1'b0;
        end else if (run_end) begin
          step_q <= step_q + STEP_W'(1);
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + ITER_W'(1);
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign step_idx_o = step_q;
  assign loop_cnt_o = cnt_q;
endmodule

// File: rtl/inv_chain_seq.sv
module inv_chain_seq
  import inv_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              uop_done_i,
  output logic              busy_o,
  output logic              uop_valid_o,
  output logic              uop_op_o,
  output logic              uop_src_bank_o,
  output logic [SLOT_W-1:0] uop_src_a_o,
  output logic [SLOT_W-1:0] uop_src_b_o,
  output logic              uop_dst_bank_o,
  output logic [SLOT_W-1:0] uop_dst_o,
  output logic              uop_mod_o,
  output logic              seq_done_o
);
  logic [STEP_W-1:0] step_idx;
  logic [ITER_W-1:0] loop_cnt;
  logic              uop_accept;
  logic              seq_last;
  step_t             cur_step;
  uop_t              cur_uop;

  inv_step_rom u_rom (
    .step_idx_i (step_idx),
    .step_o     (cur_step)
  );

  inv_uop_expand u_exp (
    .step_i     (cur_step),
    .iter_odd_i (loop_cnt[0]),
    .uop_o      (cur_uop)
  );

  inv_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .uop_done_i (uop_done_i),
    .run_i      (cur_step.is_run),
    .run_len_i  (cur_step.run_len),
    .busy_o     (busy_o),
    .step_idx_o (step_idx),
    .loop_cnt_o (loop_cnt),
    .accept_o   (uop_accept),
    .last_o     (seq_last),
    .done_o     (seq_done_o)
  );

  assign uop_valid_o    = busy_o;
  assign uop_op_o       = cur_uop.op;
  assign uop_src_bank_o = cur_uop.src_bk;
  assign uop_src_a_o    = cur_uop.src_a;
  assign uop_src_b_o    = cur_uop.src_b;
  assign uop_dst_bank_o = cur_uop.dst_bk;
  assign uop_dst_o      = cur_uop.dst;
  assign uop_mod_o      = cur_uop.md;
endmodule

// File: rtl/inv_chain_seq_chk.sv
module inv_chain_seq_chk
  import inv_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              uop_done_i,
  input logic              busy_o,
  input logic              uop_valid_o,
  input logic              uop_op_o,
  input logic              uop_src_bank_o,
  input logic [SLOT_W-1:0] uop_src_a_o,
  input logic [SLOT_W-1:0] uop_src_b_o,
  input logic              uop_dst_bank_o,
  input logic [SLOT_W-1:0] uop_dst_o,
  input logic              uop_mod_o,
  input logic              seq_done_o,
  input logic              uop_accept,
  input logic              seq_last,
  input logic [STEP_W-1:0] step_idx,
  input logic [ITER_W-1:0] loop_cnt
);
  logic              is_sq;
  logic              prev_sq_q;
  logic              prev_bk_q;
  logic [SLOT_W-1:0] prev_dst_q;

  assign is_sq = uop_valid_o && uop_op_o && (uop_src_a_o == uop_src_b_o);

  always_ff @(posedge clk) begin
    if (!rst_n || !busy_o) begin
      prev_sq_q  <= 1'b0;
      prev_bk_q  <= 1'b0;
      prev_dst_q <= '0;
    end else if (uop_accept) begin
      prev_sq_q  <= is_sq;
      prev_bk_q  <= uop_dst_bank_o;
      prev_dst_q <= uop_dst_o;
    end
  end

  // R2
  start_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && uop_valid_o));

  // R3
  hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid_o && !uop_done_i) |=> (uop_valid_o && $stable({uop_op_o, uop_src_bank_o,
      uop_src_a_o, uop_src_b_o, uop_dst_bank_o, uop_dst_o, uop_mod_o})));

  // R4
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_accept && !seq_last) |=> uop_valid_o);

  // R5
  cross_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid_o |-> (uop_dst_bank_o != uop_src_bank_o));

  // R6
  mul_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid_o && uop_op_o) |-> uop_mod_o);

  // R6
  move_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid_o && !uop_op_o) |-> (!uop_mod_o && uop_src_a_o == uop_src_b_o));

  // R7
  sq_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sq && prev_sq_q) |-> (uop_src_bank_o == prev_bk_q && uop_src_a_o == prev_dst_q));

  // R10
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_accept && seq_last) |=> seq_done_o);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done_o |-> (!uop_valid_o && !busy_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done_o |=> !seq_done_o);

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !uop_accept) |=> ($stable(step_idx) && $stable(loop_cnt)));
endmodule

bind inv_chain_seq inv_chain_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .uop_done_i     (uop_done_i),
  .busy_o         (busy_o),
  .uop_valid_o    (uop_valid_o),
  .uop_op_o       (uop_op_o),
  .uop_src_bank_o (uop_src_bank_o),
  .uop_src_a_o    (uop_src_a_o),
  .uop_src_b_o    (uop_src_b_o),
  .uop_dst_bank_o (uop_dst_bank_o),
  .uop_dst_o      (uop_dst_o),
  .uop_mod_o      (uop_mod_o),
  .seq_done_o     (seq_done_o),
  .uop_accept     (uop_accept),
  .seq_last       (seq_last),
  .step_idx       (step_idx),
  .loop_cnt       (loop_cnt)
);

// File: tb/test_inv_chain_seq.sv
`timescale 1ns/1ps
module test_inv_chain_seq;
  import inv_seq_pkg::*;

  localparam int FW = 4 + 3 * SLOT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic uop_done_i = 1'b0;
  logic busy_o, uop_valid_o, uop_op_o, uop_src_bank_o, uop_dst_bank_o, uop_mod_o, seq_done_o;
  logic [SLOT_W-1:0] uop_src_a_o, uop_src_b_o, uop_dst_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  inv_chain_seq i_inv_chain_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .uop_done_i(uop_done_i),
    .busy_o(busy_o), .uop_valid_o(uop_valid_o), .uop_op_o(uop_op_o),
    .uop_src_bank_o(uop_src_bank_o), .uop_src_a_o(uop_src_a_o), .uop_src_b_o(uop_src_b_o),
    .uop_dst_bank_o(uop_dst_bank_o), .uop_dst_o(uop_dst_o), .uop_mod_o(uop_mod_o),
    .seq_done_o(seq_done_o)
  );

  wire [FW-1:0] f_now = {uop_op_o, uop_src_bank_o, uop_src_a_o, uop_src_b_o,
                         uop_dst_bank_o, uop_dst_o, uop_mod_o};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Drives one full inversion; lat_mode 0 = immediate completion, 1 = 0..3 stall cycles.
  // poke_at >= 0 pulses start while that operation is stalled (R11).
  task automatic run_chain(input int lat_mode, input int poke_at, input string tag);
    logic [255:0] ex [0:1][0:15];
    logic [FW-1:0] cap;
    int nops = 0, n_sq = 0, n_mul = 0, n_mv = 0;
    int stall_bad = 0, bank_bad = 0, mod_bad = 0, chain_bad = 0, undef_rd = 0;
    bit prev_sq = 0;
    logic prev_bk = 0;
    logic [SLOT_W-1:0] prev_d = '0;
    logic [255:0] expect_exp;
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 16; s++) ex[b][s] = '0;
    ex[0][2] = 256'd1;

    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(busy_o && uop_valid_o, "R2", {tag, " busy/valid after start"},
        {busy_o, uop_valid_o}, 2'b11);
    chk(f_now == {1'b0, 1'b0, 4'd2, 4'd2, 1'b1, 4'd2, 1'b0}, "R2",
        {tag, " first uop fields"}, f_now, {1'b0, 1'b0, 4'd2, 4'd2, 1'b1, 4'd2, 1'b0});

    while (uop_valid_o && nops < 400) begin
      cap = f_now;
      for (int w = 0; w < ((lat_mode == 0) ? 0 : (nops % 4)); w++) begin
        if (nops == poke_at && w == 0) start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (!uop_valid_o || f_now != cap) stall_bad++;
      end
      // apply the operation symbolically (R9)
      if (uop_dst_bank_o == uop_src_bank_o) bank_bad++;
      if (uop_op_o) begin
        if (!uop_mod_o) mod_bad++;
        if (ex[uop_src_bank_o][uop_src_a_o] == 0 || ex[uop_src_bank_o][uop_src_b_o] == 0)
          undef_rd++;
        if (uop_src_a_o == uop_src_b_o) begin
          n_sq++;
          if (prev_sq && (uop_src_bank_o != prev_bk || uop_src_a_o != prev_d)) chain_bad++;
          prev_sq = 1;
        end else begin
          n_mul++;
          prev_sq = 0;
        end
        ex[uop_dst_bank_o][uop_dst_o] = ex[uop_src_bank_o][uop_src_a_o]
                                      + ex[uop_src_bank_o][uop_src_b_o];
      end else begin
        n_mv++;
        prev_sq = 0;
        if (uop_mod_o || uop_src_a_o != uop_src_b_o) mod_bad++;
        if (ex[uop_src_bank_o][uop_src_a_o] == 0) undef_rd++;
        ex[uop_dst_bank_o][uop_dst_o] = ex[uop_src_bank_o][uop_src_a_o];
      end
      prev_bk = uop_dst_bank_o;
      prev_d  = uop_dst_o;
      uop_done_i = 1'b1;
      nops++;
      @(negedge clk);
      uop_done_i = 1'b0;
    end

    chk(seq_done_o && !busy_o && !uop_valid_o, "R10", {tag, " done/busy/valid after last"},
        {seq_done_o, busy_o, uop_valid_o}, 3'b100);
    chk(nops == 291, "R4", {tag, " operation count"}, nops, 291);
    chk(n_sq == 254, "R8", {tag, " squarings"}, n_sq, 254);
    chk(n_mul == 11, "R8", {tag, " general multiplies"}, n_mul, 11);
    chk(n_mv == 26, "R8", {tag, " moves"}, n_mv, 26);
    chk(bank_bad == 0, "R5", {tag, " same-bank writes"}, bank_bad, 0);
    chk(mod_bad == 0, "R6", {tag, " mod/move form errors"}, mod_bad, 0);
    chk(chain_bad == 0, "R7", {tag, " broken squaring chain"}, chain_bad, 0);
    chk(undef_rd == 0, "R9", {tag, " reads of unwritten slots"}, undef_rd, 0);
    expect_exp = (256'd1 << 255) - 256'd21;
    chk(ex[1][0] == expect_exp, "R9", {tag, " final exponent in high slot 0"},
        ex[1][0], expect_exp);
    if (lat_mode != 0)
      chk(stall_bad == 0, "R3", {tag, " fields changed during stall"}, stall_bad, 0);
    @(negedge clk);
    chk(!seq_done_o, "R10", {tag, " done lasts one cycle"}, seq_done_o, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy_o, uop_valid_o, seq_done_o} == 3'b000, "R1", "reset state",
        {busy_o, uop_valid_o, seq_done_o}, 0);
    uop_done_i = 1'b1;
    repeat (3) @(negedge clk);
    uop_done_i = 1'b0;
    @(negedge clk);
    chk({busy_o, uop_valid_o, seq_done_o} == 3'b000, "R1", "idle with stray completion",
        {busy_o, uop_valid_o, seq_done_o}, 0);
  endtask

  task automatic t_fast();
    run_chain(0, -1, "fast");
  endtask

  task automatic t_stall_and_poke();
    // R11: start pulsed while operation 101 is stalled
    run_chain(1, 101, "stall+poke");
  endtask

  task automatic t_restart();
    // R12: back-to-back replay; run_chain starts on the cycle after the pulse check
    run_chain(1, -1, "restart R12");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog: actual no finish, expected finish");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_fast();
    t_stall_and_poke();
    t_restart();
    summary();
    $finish;
  end
endmodule